// File: doc/BRIEF.md
# Serial Flash Command Phase Sequencer

This block runs one memory-style serial transaction at a time. The transaction is split into ordered phases. An opcode phase comes first, then a combined address-and-dummy phase, then an optional data phase. Bytes for the opcode, the address (most significant byte first), the dummy bytes and any write data come in on one byte stream with a valid/ready handshake. The block shifts them onto one, two or four bidirectional lanes. For a read it releases the lanes during the data phase and returns the sampled bytes on an output stream.

Serial clock generation lives outside the block. A one-cycle `bit_tick` input marks the moment the attached device takes the current lane slice. Each accepted tick moves the sequencer by one beat: one bit per lane. When the sequencer holds no byte to send, a tick is skipped, so a stalled byte stream pauses the bus without losing data. Phase lengths and modes come from configuration inputs that are captured when `start` is seen while idle. The lanes are half-duplex: the data phase either drives or samples, and never both.

Top module: `flash_phase_seq`

## Requirements
- R1: After a synchronous active-low reset the block is idle: `cs_n`=1, `io_oe`=0, `tx_ready`=0, `rx_valid`=0, `busy`=0, `done`=0.
- R2: The opcode phase sends `cfg_cmd_bytes` stream bytes on lane 0 only (`io_oe`=4'b0001), most significant bit first, one bit per accepted tick.
- R3: The address/dummy phase sends `cfg_ad_bytes` (0 to 15) stream bytes in arrival order, directly after the opcode bytes.
- R4: `cfg_lanes` selects the data width: 0 selects one lane, 1 selects two lanes and 2 selects four lanes; 3 is treated as one lane. In two-lane beats `io_out[1:0]` carries byte bits 7:6, then 5:4, 3:2 and 1:0 (`io_oe`=4'b0011). In four-lane beats `io_out[3:0]` carries bits 7:4, then 3:0 (`io_oe`=4'b1111).
- R5: With `cfg_xmode`=1 the address/dummy phase uses one lane, while the data phase still uses the width set by `cfg_lanes`. With `cfg_xmode`=0 both phases use the `cfg_lanes` width.
- R6: With `cfg_nodata`=1, or with `cfg_data_bytes`=0, the transaction ends after the address/dummy phase. No data byte is taken from the stream and no byte is returned.
- R7: With `cfg_read`=1 the data phase drives `io_oe`=0. It samples `cfg_data_bytes` bytes from `io_in`, using `io_in[1]` in one-lane mode and the low lanes otherwise, with the same bit order as R4. Each byte is presented for exactly one cycle on `rx_valid`/`rx_data`.
- R8: With `cfg_read`=0 the data phase sends `cfg_data_bytes` stream bytes at the R4 width.
- R9: A tick that arrives while no byte is held is ignored. A stalled stream pauses the phase without skipping or repeating any slice, and no byte is taken from the stream beyond the transaction's count.
- R10: After the last beat, `done` is high for exactly one cycle, during which `cs_n`=1. The next cycle `busy`=0. `cs_n` is low only while a phase is running, and `io_oe` is 0 whenever `cs_n`=1.
- R11: A phase whose byte count is zero is skipped and takes no ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transaction (sampled while idle) |
| cfg_cmd_bytes | input | 4 | Opcode phase byte count |
| cfg_ad_bytes | input | 4 | Combined address and dummy byte count |
| cfg_lanes | input | 2 | Lane width code (lanes / 2) |
| cfg_xmode | input | 1 | Keep address/dummy on one lane |
| cfg_nodata | input | 1 | Omit the data phase |
| cfg_read | input | 1 | Data phase direction, 1 = read |
| cfg_data_bytes | input | LEN_W | Data phase byte count |
| bit_tick | input | 1 | One beat of the serial clock |
| tx_valid | input | 1 | Stream byte available |
| tx_data | input | 8 | Stream byte |
| tx_ready | output | 1 | Sequencer takes a stream byte |
| rx_valid | output | 1 | Read byte valid, one cycle |
| rx_data | output | 8 | Read byte |
| io_in | input | 4 | Lane input values |
| io_out | output | 4 | Lane drive values |
| io_oe | output | 4 | Lane drive enables |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |

## Verification
The assertions assume that `bit_tick` is never high on two consecutive cycles while a four-lane read runs. They also assume that configuration inputs matter only in the cycle where `start` is accepted. The bench raises the tick on one cycle in four, and it changes configuration only while the block is idle. The stream never offers more bytes than a transaction consumes, so a byte taken beyond the count would show up as a count mismatch rather than as a hidden overrun. During reads the bench drives the lanes the block should ignore with the inverse of the expected bit, so sampling a wrong lane changes the returned byte.

// File: rtl/flash_seq_pkg.sv
// Shared types and lane helpers for the serial flash phase sequencer.
// Assumes widths of 1, 2 or 4 lanes only.
package flash_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_CMD  = 3'd1,
        PH_ADDR = 3'd2,
        PH_DATA = 3'd3,
        PH_FIN  = 3'd4
    } phase_e;

    // Lane count for a width code; the spare code falls back to one lane.
    function automatic logic [2:0] lane_width(input logic [1:0] code);
        case (code)
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    // Output-enable mask for a lane count.
    function automatic logic [3:0] lane_mask(input logic [2:0] w);
        case (w)
            3'd4:    return 4'b1111;
            3'd2:    return 4'b0011;
            default: return 4'b0001;
        endcase
    endfunction

    // Index of the final beat of a byte for a lane count.
    function automatic logic [2:0] last_beat(input logic [2:0] w);
        case (w)
            3'd4:    return 3'd1;
            3'd2:    return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/flash_seq_ctrl.sv
// Phase controller: walks opcode, address/dummy and data phases, counting
// bytes and beats. Assumes configuration is only meaningful at start.
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [3:0]       cfg_cmd_bytes,
    input  logic [3:0]       cfg_ad_bytes,
    input  logic [1:0]       cfg_lanes,
    input  logic             cfg_xmode,
    input  logic             cfg_nodata,
    input  logic             cfg_read,
    input  logic [LEN_W-1:0] cfg_data_bytes,
    input  logic             bit_tick,
    input  logic             tx_have,
    output phase_e           phase,
    output logic [2:0]       width,
    output logic             is_tx,
    output logic             is_rd,
    output logic             fire,
    output logic             byte_end
);

    phase_e           phase_q;
    logic [LEN_W-1:0] left_q;
    logic [2:0]       beat_q;
    logic [3:0]       ad_q;
    logic [1:0]       lanes_q;
    logic             xm_q;
    logic             rd_q;
    logic             data_q;
    logic [LEN_W-1:0] dlen_q;

    logic             data_in;
    logic             idle;
    logic [3:0]       ad_src;
    logic             data_src;
    logic [LEN_W-1:0] dlen_src;
    phase_e           post_cmd_ph;
    logic [LEN_W-1:0] post_cmd_len;
    logic             beat_last;

    assign data_in  = !cfg_nodata && (cfg_data_bytes != '0);
    assign idle     = (phase_q == PH_IDLE);
    assign ad_src   = idle ? cfg_ad_bytes   : ad_q;
    assign data_src = idle ? data_in        : data_q;
    assign dlen_src = idle ? cfg_data_bytes : dlen_q;

    // Choose the phase that follows the opcode phase (or replaces it).
    always_comb begin
        if (ad_src != '0) begin
            post_cmd_ph  = PH_ADDR;
            post_cmd_len = LEN_W'(ad_src);
        end else if (data_src) begin
            post_cmd_ph  = PH_DATA;
            post_cmd_len = dlen_src;
        end else begin
            post_cmd_ph  = PH_FIN;
            post_cmd_len = '0;
        end
    end

    // Lane count of the running phase.
    always_comb begin
        case (phase_q)
            PH_ADDR: width = xm_q ? 3'd1 : lane_width(lanes_q);
            PH_DATA: width = lane_width(lanes_q);
            default: width = 3'd1;
        endcase
    end

    assign phase     = phase_q;
    assign is_rd     = (phase_q == PH_DATA) && rd_q;
    assign is_tx     = (phase_q == PH_CMD) || (phase_q == PH_ADDR) ||
                       ((phase_q == PH_DATA) && !rd_q);
    assign fire      = bit_tick && (is_rd || (is_tx && tx_have));
    assign beat_last = (beat_q == last_beat(width));
    assign byte_end  = fire && beat_last;

    // Phase, byte and beat sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            left_q  <= '0;
            beat_q  <= '0;
            ad_q    <= '0;
            lanes_q <= '0;
            xm_q    <= 1'b0;
            rd_q    <= 1'b0;
            data_q  <= 1'b0;
            dlen_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        ad_q    <= cfg_ad_bytes;
                        lanes_q <= cfg_lanes;
                        xm_q    <= cfg_xmode;
                        rd_q    <= cfg_read;
                        data_q  <= data_in;
                        dlen_q  <= cfg_data_bytes;
                        beat_q  <= '0;
                        if (cfg_cmd_bytes != '0) begin
                            phase_q <= PH_CMD;
                            left_q  <= LEN_W'(cfg_cmd_bytes);
                        end else begin
                            phase_q <= post_cmd_ph;
                            left_q  <= post_cmd_len;
                        end
                    end
                end
                PH_CMD, PH_ADDR, PH_DATA: begin
                    if (fire) begin
                        beat_q <= beat_last ? 3'd0 : beat_q + 3'd1;
                    end
                    if (byte_end) begin
                        if (left_q == LEN_W'(1)) begin
                            if (phase_q == PH_CMD) begin
                                phase_q <= post_cmd_ph;
                                left_q  <= post_cmd_len;
                            end else if (phase_q == PH_ADDR && data_q) begin
                                phase_q <= PH_DATA;
                                left_q  <= dlen_q;
                            end else begin
                                phase_q <= PH_FIN;
                                left_q  <= '0;
                            end
                        end else begin
                            left_q <= left_q - LEN_W'(1);
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/flash_seq_tx.sv
// Transmit shifter: takes one stream byte at a time and presents its
// most significant bits as the current lane slice. Assumes width is 1/2/4.
module flash_seq_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       is_tx,
    input  logic       fire,
    input  logic       byte_end,
    input  logic [2:0] width,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       have,
    output logic [3:0] lanes
);

    logic [7:0] sh_q;
    logic       have_q;

    assign tx_ready = is_tx && !have_q;
    assign have     = have_q;

    // Slice of the held byte for the current lane count.
    always_comb begin
        case (width)
            3'd4:    lanes = sh_q[7:4];
            3'd2:    lanes = {2'b00, sh_q[7:6]};
            default: lanes = {3'b000, sh_q[7]};
        endcase
    end

    // Load a byte, then shift it out one slice per accepted tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            have_q <= 1'b0;
        end else if (tx_ready && tx_valid) begin
            sh_q   <= tx_data;
            have_q <= 1'b1;
        end else if (fire && is_tx) begin
            sh_q <= sh_q << width;
            if (byte_end) begin
                have_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/flash_seq_rx.sv
// Receive assembler: gathers lane slices into bytes in transmit bit order
// and pulses each completed byte. Single-lane reads use lane 1.
module flash_seq_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       is_rd,
    input  logic       fire,
    input  logic       byte_end,
    input  logic [2:0] width,
    input  logic [3:0] io_in,
    output logic       rx_valid,
    output logic [7:0] rx_data
);

    logic [7:0] acc_q;
    logic [3:0] slice;
    logic [7:0] acc_next;

    // Pick the sampled lanes for the current lane count.
    always_comb begin
        case (width)
            3'd4:    slice = io_in;
            3'd2:    slice = {2'b00, io_in[1:0]};
            default: slice = {3'b000, io_in[1]};
        endcase
        acc_next = (acc_q << width) | {4'b0000, slice};
    end

    // Shift in one slice per accepted tick; publish at the byte's last beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (fire && is_rd) begin
                acc_q <= acc_next;
                if (byte_end) begin
                    rx_valid <= 1'b1;
                    rx_data  <= acc_next;
                end
            end
        end
    end

endmodule

// File: rtl/flash_phase_seq.sv
// Top of the serial flash phase sequencer: ties the phase controller, the
// transmit shifter and the receive assembler to the lane pins.
// Assumes bit_tick is produced by an external serial clock engine.
module flash_phase_seq
    import flash_seq_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [3:0]       cfg_cmd_bytes,
    input  logic [3:0]       cfg_ad_bytes,
    input  logic [1:0]       cfg_lanes,
    input  logic             cfg_xmode,
    input  logic             cfg_nodata,
    input  logic             cfg_read,
    input  logic [LEN_W-1:0] cfg_data_bytes,
    input  logic             bit_tick,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    input  logic [3:0]       io_in,
    output logic [3:0]       io_out,
    output logic [3:0]       io_oe,
    output logic             cs_n,
    output logic             busy,
    output logic             done
);

    phase_e     phase;
    logic [2:0] width;
    logic       is_tx;
    logic       is_rd;
    logic       fire;
    logic       byte_end;
    logic       tx_have;
    logic [3:0] tx_lanes;

    flash_seq_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .cfg_cmd_bytes  (cfg_cmd_bytes),
        .cfg_ad_bytes   (cfg_ad_bytes),
        .cfg_lanes      (cfg_lanes),
        .cfg_xmode      (cfg_xmode),
        .cfg_nodata     (cfg_nodata),
        .cfg_read       (cfg_read),
        .cfg_data_bytes (cfg_data_bytes),
        .bit_tick       (bit_tick),
        .tx_have        (tx_have),
        .phase          (phase),
        .width          (width),
        .is_tx          (is_tx),
        .is_rd          (is_rd),
        .fire           (fire),
        .byte_end       (byte_end)
    );

    flash_seq_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_tx    (is_tx),
        .fire     (fire),
        .byte_end (byte_end),
        .width    (width),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .have     (tx_have),
        .lanes    (tx_lanes)
    );

    flash_seq_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_rd    (is_rd),
        .fire     (fire),
        .byte_end (byte_end),
        .width    (width),
        .io_in    (io_in),
        .rx_valid (rx_valid),
        .rx_data  (rx_data)
    );

    // Drive only the lanes of the current width, and only while sending.
    always_comb begin
        io_oe  = is_tx ? lane_mask(width) : 4'b0000;
        io_out = tx_lanes & io_oe;
    end

    assign cs_n = !((phase == PH_CMD) || (phase == PH_ADDR) || (phase == PH_DATA));
    assign busy = (phase != PH_IDLE);
    assign done = (phase == PH_FIN);

endmodule

// File: rtl/flash_phase_seq_chk.sv
// Protocol checker for the phase sequencer, attached by bind.
module flash_phase_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_tick,
    input logic       tx_ready,
    input logic       rx_valid,
    input logic [3:0] io_oe,
    input logic       cs_n,
    input logic       busy,
    input logic       done
);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r10_cs_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    a_r10_no_drive_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (io_oe == 4'b0000));

    a_r4_oe_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (io_oe == 4'b0000) || (io_oe == 4'b0001) ||
        (io_oe == 4'b0011) || (io_oe == 4'b1111));

    a_r7_rx_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(bit_tick));

    a_r7_rx_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r9_ready_in_txn: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !cs_n);

endmodule

bind flash_phase_seq flash_phase_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .tx_ready (tx_ready),
    .rx_valid (rx_valid),
    .io_oe    (io_oe),
    .cs_n     (cs_n),
    .busy     (busy),
    .done     (done)
);

// File: tb/flash_phase_seq_tb.sv
`timescale 1ns/100ps
module flash_phase_seq_tb;

    localparam int LEN_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [3:0]       cfg_cmd_bytes = '0;
    logic [3:0]       cfg_ad_bytes = '0;
    logic [1:0]       cfg_lanes = '0;
    logic             cfg_xmode = 1'b0;
    logic             cfg_nodata = 1'b0;
    logic             cfg_read = 1'b0;
    logic [LEN_W-1:0] cfg_data_bytes = '0;
    logic             bit_tick;
    logic             tx_valid;
    logic [7:0]       tx_data;
    logic             tx_ready;
    logic             rx_valid;
    logic [7:0]       rx_data;
    logic [3:0]       io_in = '0;
    logic [3:0]       io_out;
    logic [3:0]       io_oe;
    logic             cs_n;
    logic             busy;
    logic             done;

    always #2.5 clk = ~clk;

    flash_phase_seq #(.LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_cmd_bytes(cfg_cmd_bytes), .cfg_ad_bytes(cfg_ad_bytes),
        .cfg_lanes(cfg_lanes), .cfg_xmode(cfg_xmode), .cfg_nodata(cfg_nodata),
        .cfg_read(cfg_read), .cfg_data_bytes(cfg_data_bytes),
        .bit_tick(bit_tick), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
        .cs_n(cs_n), .busy(busy), .done(done)
    );

    int nchk = 0;
    int nfail = 0;

    // Stream source and tick generator state.
    logic [7:0] stream [0:63];
    logic [7:0] rdb    [0:63];
    int         slen = 0;
    int         sidx = 0;
    logic       clr = 1'b0;
    logic       gap_mode = 1'b0;
    logic [3:0] gcnt = '0;
    logic [1:0] tcnt = '0;
    int         cur_w = 1;

    // Observation logs.
    logic [3:0] log_oe  [0:255];
    logic [3:0] log_out [0:255];
    logic [3:0] exp_oe  [0:255];
    logic [3:0] exp_out [0:255];
    logic [7:0] rxlog   [0:63];
    int         nlog = 0;
    int         nexp = 0;
    int         nrx = 0;
    int         rdk = 0;
    int         ndone = 0;

    assign bit_tick = (tcnt == 2'd3);
    assign tx_valid = (sidx < slen) && !(gap_mode && gcnt[3]);
    assign tx_data  = stream[sidx[5:0]];

    // Free-running tick and gap counters; stream index advance on handshake.
    always @(posedge clk) begin
        tcnt <= tcnt + 2'd1;
        gcnt <= gcnt + 4'd1;
        if (clr)                        sidx <= 0;
        else if (tx_valid && tx_ready)  sidx <= sidx + 1;
    end

    function automatic logic [3:0] mask_of(input int w);
        return (w == 4) ? 4'b1111 : (w == 2) ? 4'b0011 : 4'b0001;
    endfunction

    function automatic logic [3:0] slice_of(input logic [7:0] b, input int w, input int k);
        return 4'((b >> (8 - w * (k + 1)))) & mask_of(w);
    endfunction

    // Lane pattern for the k-th read beat; unused lanes carry the inverse bit.
    function automatic logic [3:0] rd_drive(input int k);
        int beats;
        logic [3:0] sl;
        beats = 8 / cur_w;
        sl = slice_of(rdb[(k / beats) & 63], cur_w, k % beats);
        if (cur_w == 1)      return {2'b00, sl[0], ~sl[0]};
        else if (cur_w == 2) return {~sl[1:0], sl[1:0]};
        else                 return sl;
    endfunction

    // Sample outputs mid-cycle: log sent slices, feed read lanes, collect bytes.
    always @(negedge clk) begin
        if (clr) begin
            nlog = 0; nrx = 0; rdk = 0; ndone = 0;
        end else begin
            if (bit_tick && !cs_n && io_oe != 4'b0000 && !tx_ready) begin
                if (nlog < 256) begin
                    log_oe[nlog]  = io_oe;
                    log_out[nlog] = io_out;
                end
                nlog++;
            end
            if (bit_tick && !cs_n && io_oe == 4'b0000) begin
                io_in = rd_drive(rdk);
                rdk++;
            end
            if (rx_valid) begin
                if (nrx < 64) rxlog[nrx] = rx_data;
                nrx++;
            end
            if (done) ndone++;
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_val(input int seed, input int idx);
        return 8'((seed * 53 + idx * 29 + 7) ^ (idx << 3));
    endfunction

    task automatic add_exp(input logic [7:0] b, input int w);
        for (int k = 0; k < 8 / w; k++) begin
            exp_oe[nexp]  = mask_of(w);
            exp_out[nexp] = slice_of(b, w, k);
            nexp++;
        end
    endtask

    int seed_ctr = 1;

    task automatic run_txn(input int cmd, input int ad, input int lanes,
                           input int xm, input int nd, input int rd,
                           input int dl, input int gap, input string tag);
        int wl, wa, present, ns, nrx_exp, mism, first_bad, waited;
        logic [7:0] b;
        wl = (lanes == 1) ? 2 : (lanes == 2) ? 4 : 1;
        wa = xm ? 1 : wl;
        present = (nd == 0 && dl != 0) ? 1 : 0;
        nexp = 0;
        ns = 0;
        seed_ctr++;
        for (int i = 0; i < cmd; i++) begin
            b = byte_val(seed_ctr, ns); stream[ns] = b; add_exp(b, 1); ns++;
        end
        for (int i = 0; i < ad; i++) begin
            b = byte_val(seed_ctr, ns); stream[ns] = b; add_exp(b, wa); ns++;
        end
        if (present == 1 && rd == 0) begin
            for (int i = 0; i < dl; i++) begin
                b = byte_val(seed_ctr, ns); stream[ns] = b; add_exp(b, wl); ns++;
            end
        end
        for (int i = 0; i < dl; i++) rdb[i] = byte_val(seed_ctr + 100, i);
        nrx_exp = (present == 1 && rd == 1) ? dl : 0;

        @(posedge clk); #1;
        clr = 1'b1;
        slen = ns;
        gap_mode = gap[0];
        cur_w = wl;
        cfg_cmd_bytes = 4'(cmd); cfg_ad_bytes = 4'(ad); cfg_lanes = 2'(lanes);
        cfg_xmode = xm[0]; cfg_nodata = nd[0]; cfg_read = rd[0];
        cfg_data_bytes = LEN_W'(dl);
        @(posedge clk); #1;
        clr = 1'b0;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;

        waited = 0;
        while (ndone == 0 && waited < 5000) begin
            @(posedge clk); #1;
            waited++;
        end
        check(waited < 5000, {"R10 ", tag}, "transaction finished", waited, 0);
        #1;
        check(cs_n == 1'b1 && busy == 1'b0, {"R10 ", tag}, "idle after done",
              {cs_n, busy}, 2);
        repeat (2) @(posedge clk);
        #1;
        check(ndone == 1, {"R10 ", tag}, "done pulse cycles", ndone, 1);
        check(nlog == nexp, {"R2/", tag}, "driven beats", nlog, nexp);
        mism = 0; first_bad = -1;
        for (int i = 0; i < nexp && i < nlog; i++) begin
            if (log_oe[i] != exp_oe[i] || log_out[i] != exp_out[i]) begin
                if (first_bad < 0) first_bad = i;
                mism++;
            end
        end
        if (first_bad >= 0)
            check(1'b0, {"R3/", tag}, "beat slice {oe,out}",
                  {log_oe[first_bad], log_out[first_bad]},
                  {exp_oe[first_bad], exp_out[first_bad]});
        else
            check(1'b1, {"R3/", tag}, "beat slices", 0, 0);
        check(sidx == ns, {"R9 ", tag}, "stream bytes taken", sidx, ns);
        check(nrx == nrx_exp, {"R7 ", tag}, "read byte count", nrx, nrx_exp);
        mism = 0; first_bad = -1;
        for (int i = 0; i < nrx_exp && i < nrx; i++) begin
            if (rxlog[i] != rdb[i]) begin
                if (first_bad < 0) first_bad = i;
                mism++;
            end
        end
        if (first_bad >= 0)
            check(1'b0, {"R7 ", tag}, "read byte", rxlog[first_bad], rdb[first_bad]);
        else
            check(1'b1, {"R7 ", tag}, "read bytes", 0, 0);
    endtask

    task automatic run_all();
        repeat (4) @(posedge clk);
        #1;
        check(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
        check(io_oe == 4'b0000, "R1", "io_oe in reset", io_oe, 0);
        check(tx_ready == 1'b0 && rx_valid == 1'b0, "R1", "handshakes in reset",
              {tx_ready, rx_valid}, 0);
        check(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset",
              {busy, done}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(cs_n == 1'b1 && busy == 1'b0, "R1", "idle after reset", {cs_n, busy}, 2);

        // Sweep lane code, address mode and direction.
        for (int ln = 0; ln < 4; ln++)
            for (int xm = 0; xm < 2; xm++)
                for (int rd = 0; rd < 2; rd++)
                    run_txn(1, 3, ln, xm, 0, rd, 3, 0,
                            $sformatf("%s %s lanes=%0d", xm ? "R5" : "R4",
                                      rd ? "R7" : "R8", ln));

        run_txn(1, 4, 2, 0, 1, 1, 5, 0, "R6 nodata read");
        run_txn(1, 2, 1, 1, 1, 0, 3, 0, "R6 nodata write");
        run_txn(1, 2, 2, 0, 0, 1, 0, 0, "R6 zero length");
        run_txn(1, 3, 2, 0, 0, 0, 6, 1, "R9 stalled write");
        run_txn(1, 5, 1, 1, 0, 1, 4, 1, "R9 stalled read");
        run_txn(0, 2, 1, 0, 0, 1, 2, 0, "R11 no opcode");
        run_txn(1, 0, 2, 0, 0, 0, 3, 0, "R11 no address");
        run_txn(0, 0, 2, 0, 1, 0, 0, 0, "R11 empty");
        run_txn(2, 15, 2, 0, 0, 1, 1, 0, "R3 max addr");
        run_txn(1, 15, 1, 1, 0, 0, 2, 0, "R3 R5 max addr xmode");
    endtask

    initial begin
        logic wd;
        wd = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) check(1'b0, "R10", "watchdog expired", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule